// File: doc/BRIEF.md
# PWM Fault Auto-Shutdown Controller

This block sits between a PWM waveform generator and the four bridge driver pins. It watches two comparator trip inputs and an active-low fault pin. When any source that software has enabled trips, it overrides all four pins with programmed safe values at once, through a purely combinational path, so there is no wait for a clock edge. The pins are handled as two pairs, A/C and B/D. Each pair can be driven low, driven high, or released (output-enable low).

A parallel path passes the trip sources through a two-flop synchronizer and sets a sticky shutdown flag. While the flag is set, the pins stay safe. The flag is cleared in one of two ways. With automatic restart on, it clears itself once the synchronized trip is gone. With automatic restart off, software must clear it, and software writes to the flag are ignored while a synchronized trip is still present. After the flag clears, a release state machine keeps the pins safe until the next period-start strobe. A period that begins with the flag set therefore stays fully shut down.

The release state machine has three states. RUN means the pins follow the PWM. HOLD means the flag is set. ARMED means the flag is clear and the machine is waiting for a period start. Its transitions are:
- RUN→HOLD when the flag is seen set.
- HOLD→ARMED when the flag is seen clear.
- ARMED→HOLD when the flag sets again.
- ARMED→RUN on a period-start strobe with the flag clear.

Top module: `pwm_trip_guard`

## Requirements
- R1: `cfg_src_sel` enables the trip sources. Bit 0 enables `cmp1_trip` (trips when high), bit 1 enables `cmp2_trip` (trips when high), and bit 2 enables `fault_n` (trips when low). A source whose bit is 0 has no effect on the pins or the flag, and a value of 0 disables shutdown entirely.
- R2: While any enabled source trips, the pins show their shutdown values in the same cycle, with no clock edge needed.
- R3: Shutdown code per pair: 00 drives the pin low with enable high, 01 drives it high with enable high, and 1x gives enable low with data 0. `cfg_state_ac` applies to pins 0 (A) and 2 (C), and `cfg_state_bd` applies to pins 1 (B) and 3 (D). Pin index i is bit i of `pin_out` and `pin_oe`.
- R4: An enabled trip that is present before a rising edge sets `trip_flag` at the third rising edge. The first two edges load the synchronizer.
- R5: While `trip_flag` is 1, the pins show their shutdown values. The flag stays 1 while the synchronized trip is present.
- R6: With `cfg_auto_restart`=1, the flag clears at the third rising edge after the trip goes away.
- R7: With `cfg_auto_restart`=0, the flag stays 1 after the trip goes away until software writes 0 to it (`flag_we`=1, `flag_wdata`=0).
- R8: A software write to the flag while a synchronized trip is present is ignored.
- R9: With no trip present, a software write of 1 sets the flag and shuts the pins down.
- R10: After the flag clears, the pins stay in shutdown until a `period_start` strobe arrives with the state machine in ARMED. The pins follow `pwm_raw` from the cycle after that strobe. A strobe that arrives while the flag is set does not release the pins.
- R11: After reset, the flag is 0, the state is RUN, all configuration fields are 0, `pin_out` equals `pwm_raw`, and `pin_oe` is all ones.
- R12: `cfg_we`=1 loads `cfg_src_sel`, `cfg_state_ac`, `cfg_state_bd` and `cfg_auto_restart` together at the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwm_raw | input | 4 | Generator outputs, bit 0 A to bit 3 D |
| cmp1_trip | input | 1 | Comparator 1 trip, active high |
| cmp2_trip | input | 1 | Comparator 2 trip, active high |
| fault_n | input | 1 | Fault pin, active low |
| period_start | input | 1 | One-cycle strobe at the start of a PWM period |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_src_sel | input | 3 | Trip source enables |
| cfg_state_ac | input | 2 | Shutdown code for pins A and C |
| cfg_state_bd | input | 2 | Shutdown code for pins B and D |
| cfg_auto_restart | input | 1 | Automatic flag clear enable |
| flag_we | input | 1 | Software write strobe for the flag |
| flag_wdata | input | 1 | Value written to the flag |
| pin_out | output | 4 | Final pin data |
| pin_oe | output | 4 | Per-pin output enable |
| trip_flag | output | 1 | Sticky shutdown status flag |

## Verification
The bench checks the immediate override in the same cycle as the trip. A design that applied the override only through the synchronized flag would show raw PWM for three cycles.

It samples the flag exactly at the third edge, both when the flag sets and when it clears under automatic restart. This catches a synchronizer with one stage too few or too many.

It tries to clear the flag while a trip is held. A design that accepted this write would drop the shutdown status during a live fault.

It clears the flag and then looks at the pins before and after a period strobe, including a strobe that arrives while the flag is set. A design that released on the flag alone, or ignored the period boundary, would resume mid-period.

// File: rtl/pwm_trip_pkg.sv
package pwm_trip_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_HOLD  = 2'd1,
        ST_ARMED = 2'd2
    } release_state_e;

    // Safe code: 00 low, 01 high, 1x released. Returns {oe, data}.
    function automatic logic [1:0] safe_drive(input logic [1:0] code);
        logic [1:0] r;
        if (code[1]) r = 2'b00;
        else         r = {1'b1, code[0]};
        return r;
    endfunction

endpackage

// File: rtl/trip_sync.sv
module trip_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/trip_flag.sv
module trip_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_event,
    input  logic auto_restart,
    input  logic flag_we,
    input  logic flag_wdata,
    output logic flag_q
);
    logic flag_d;

    always_comb begin
        flag_d = flag_q;
        if (sync_event)        flag_d = 1'b1;
        else if (flag_we)      flag_d = flag_wdata;
        else if (auto_restart) flag_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    // R8: software clear is refused while a synchronized trip is present
    a_r8_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_event && flag_we && !flag_wdata) |=> flag_q);

    // R5: flag stays set while the trip persists
    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && sync_event) |=> flag_q);

    // R6: automatic restart clears the flag once the trip is gone
    a_r6_auto_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && auto_restart && !sync_event && !flag_we) |=> !flag_q);

    // R7: without restart and without a write the flag holds
    a_r7_manual_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !auto_restart && !flag_we) |=> flag_q);
endmodule

// File: rtl/release_fsm.sv
module release_fsm
    import pwm_trip_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flag,
    input  logic period_start,
    output logic hold_active
);
    release_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (flag) state_d = ST_HOLD;
            ST_HOLD:  if (!flag) state_d = ST_ARMED;
            ST_ARMED: begin
                if (flag)              state_d = ST_HOLD;
                else if (period_start) state_d = ST_RUN;
            end
            default:  state_d = ST_HOLD;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_RUN:  hold_active = 1'b0;
            default: hold_active = 1'b1;
        endcase
    end

    // R10: normal output resumes only right after a period strobe
    a_r10_resume_on_period: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RUN && state_d == ST_RUN) |-> (period_start && !flag));

    // R10: a strobe with the flag set never releases
    a_r10_flag_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && state_q != ST_RUN) |=> (state_q != ST_RUN));
endmodule

// File: rtl/pin_override.sv
module pin_override
    import pwm_trip_pkg::*;
#(
    parameter int PINS = 4
) (
    input  logic [PINS-1:0] pwm_raw,
    input  logic            force_safe,
    input  logic [1:0]      code_even,
    input  logic [1:0]      code_odd,
    output logic [PINS-1:0] pin_out,
    output logic [PINS-1:0] pin_oe
);
    generate
        for (genvar i = 0; i < PINS; i++) begin : g_pin
            logic [1:0] drv;
            if (i % 2 == 0) begin : g_even
                assign drv = safe_drive(code_even);
            end else begin : g_odd
                assign drv = safe_drive(code_odd);
            end
            assign pin_out[i] = force_safe ? drv[0] : pwm_raw[i];
            assign pin_oe[i]  = force_safe ? drv[1] : 1'b1;
        end
    endgenerate
endmodule

// File: rtl/pwm_trip_guard.sv
module pwm_trip_guard
    import pwm_trip_pkg::*;
#(
    parameter int PIN_COUNT   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PIN_COUNT-1:0] pwm_raw,
    input  logic                 cmp1_trip,
    input  logic                 cmp2_trip,
    input  logic                 fault_n,
    input  logic                 period_start,
    input  logic                 cfg_we,
    input  logic [2:0]           cfg_src_sel,
    input  logic [1:0]           cfg_state_ac,
    input  logic [1:0]           cfg_state_bd,
    input  logic                 cfg_auto_restart,
    input  logic                 flag_we,
    input  logic                 flag_wdata,
    output logic [PIN_COUNT-1:0] pin_out,
    output logic [PIN_COUNT-1:0] pin_oe,
    output logic                 trip_flag
);
    localparam int SRC_COUNT = 3;

    logic [SRC_COUNT-1:0] src_sel_q;
    logic [1:0]           code_ac_q, code_bd_q;
    logic                 auto_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_sel_q <= '0;
            code_ac_q <= '0;
            code_bd_q <= '0;
            auto_q    <= 1'b0;
        end else if (cfg_we) begin
            src_sel_q <= cfg_src_sel;
            code_ac_q <= cfg_state_ac;
            code_bd_q <= cfg_state_bd;
            auto_q    <= cfg_auto_restart;
        end
    end

    logic [SRC_COUNT-1:0] raw_trip, synced_trip;
    logic                 live_event, sync_event, flag_q, hold_active, force_safe;

    assign raw_trip   = {~fault_n, cmp2_trip, cmp1_trip};
    assign live_event = |(raw_trip & src_sel_q);

    trip_sync #(.WIDTH(SRC_COUNT), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_trip),
        .sync_out (synced_trip)
    );

    assign sync_event = |(synced_trip & src_sel_q);

    trip_flag u_flag (
        .clk          (clk),
        .rst_n        (rst_n),
        .sync_event   (sync_event),
        .auto_restart (auto_q),
        .flag_we      (flag_we),
        .flag_wdata   (flag_wdata),
        .flag_q       (flag_q)
    );

    release_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .flag         (flag_q),
        .period_start (period_start),
        .hold_active  (hold_active)
    );

    assign force_safe = live_event | flag_q | hold_active;

    pin_override #(.PINS(PIN_COUNT)) u_pins (
        .pwm_raw    (pwm_raw),
        .force_safe (force_safe),
        .code_even  (code_ac_q),
        .code_odd   (code_bd_q),
        .pin_out    (pin_out),
        .pin_oe     (pin_oe)
    );

    assign trip_flag = flag_q;

    // Expected safe pattern for the checks below
    logic [PIN_COUNT-1:0] safe_out, safe_oe;
    always_comb begin
        for (int i = 0; i < PIN_COUNT; i++) begin
            logic [1:0] d;
            d = safe_drive((i % 2 == 0) ? code_ac_q : code_bd_q);
            safe_out[i] = d[0];
            safe_oe[i]  = d[1];
        end
    end

    // R2: an enabled live trip overrides the pins without a clock
    a_r2_live_override: assert property (@(posedge clk) disable iff (!rst_n)
        live_event |-> (pin_out == safe_out && pin_oe == safe_oe));

    // R5: a set flag keeps the pins safe
    a_r5_flag_override: assert property (@(posedge clk) disable iff (!rst_n)
        trip_flag |-> (pin_out == safe_out && pin_oe == safe_oe));

    // R1: with no source enabled the flag is never set by hardware
    a_r1_no_source: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel_q == '0 && !trip_flag && !flag_we) |=> !trip_flag);
endmodule

// File: tb/pwm_trip_guard_test.sv
`timescale 1ns/1ps
module pwm_trip_guard_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] pwm_raw = 4'b1010;
    logic       cmp1_trip = 1'b0, cmp2_trip = 1'b0, fault_n = 1'b1;
    logic       period_start = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_src_sel = '0;
    logic [1:0] cfg_state_ac = '0, cfg_state_bd = '0;
    logic       cfg_auto_restart = 1'b0;
    logic       flag_we = 1'b0, flag_wdata = 1'b0;
    logic [3:0] pin_out, pin_oe;
    logic       trip_flag;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pwm_trip_guard uut (
        .clk(clk), .rst_n(rst_n), .pwm_raw(pwm_raw),
        .cmp1_trip(cmp1_trip), .cmp2_trip(cmp2_trip), .fault_n(fault_n),
        .period_start(period_start), .cfg_we(cfg_we), .cfg_src_sel(cfg_src_sel),
        .cfg_state_ac(cfg_state_ac), .cfg_state_bd(cfg_state_bd),
        .cfg_auto_restart(cfg_auto_restart), .flag_we(flag_we),
        .flag_wdata(flag_wdata), .pin_out(pin_out), .pin_oe(pin_oe),
        .trip_flag(trip_flag)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // {oe, out}; code 00 low, 01 high, 1x released; even pins use ac
    function automatic logic [7:0] exp_pins(input logic shut, input logic [3:0] raw,
                                            input logic [1:0] ac, input logic [1:0] bd);
        logic [3:0] o, e;
        for (int i = 0; i < 4; i++) begin
            logic [1:0] c;
            c = (i % 2 == 0) ? ac : bd;
            if (!shut)     begin o[i] = raw[i]; e[i] = 1'b1; end
            else if (c[1]) begin o[i] = 1'b0;   e[i] = 1'b0; end
            else           begin o[i] = c[0];   e[i] = 1'b1; end
        end
        return {e, o};
    endfunction

    task automatic write_cfg(input logic [2:0] sel, input logic [1:0] ac,
                             input logic [1:0] bd, input logic ar);
        cfg_src_sel = sel; cfg_state_ac = ac; cfg_state_bd = bd;
        cfg_auto_restart = ar; cfg_we = 1'b1;
        tick(1);
        cfg_we = 1'b0;
    endtask

    task automatic sw_flag(input logic v);
        flag_wdata = v; flag_we = 1'b1;
        tick(1);
        flag_we = 1'b0;
    endtask

    task automatic pulse_period();
        period_start = 1'b1;
        tick(1);
        period_start = 1'b0;
    endtask

    task automatic t_reset();
        #1;
        chk("R11 flag", {7'd0, trip_flag}, 8'd0);
        chk("R11 pins", {pin_oe, pin_out}, exp_pins(1'b0, pwm_raw, 2'b00, 2'b00));
    endtask

    task automatic t_disabled();
        cmp1_trip = 1'b1; cmp2_trip = 1'b1; fault_n = 1'b0;
        #1;
        chk("R1 none selected pins", {pin_oe, pin_out}, exp_pins(1'b0, pwm_raw, 2'b00, 2'b00));
        tick(5);
        chk("R1 none selected flag", {7'd0, trip_flag}, 8'd0);
        cmp1_trip = 1'b0; cmp2_trip = 1'b0; fault_n = 1'b1;
        tick(3);
    endtask

    task automatic t_manual();
        write_cfg(3'b001, 2'b01, 2'b00, 1'b0);
        chk("R12 cfg loaded no trip", {pin_oe, pin_out}, exp_pins(1'b0, pwm_raw, 2'b01, 2'b00));
        cmp2_trip = 1'b1;
        tick(4);
        chk("R1 unselected cmp2", {pin_oe, pin_out, 1'b0} >> 1, exp_pins(1'b0, pwm_raw, 2'b01, 2'b00));
        chk("R1 unselected cmp2 flag", {7'd0, trip_flag}, 8'd0);
        cmp2_trip = 1'b0;
        tick(3);
        cmp1_trip = 1'b1;
        #1;
        chk("R2 immediate", {pin_oe, pin_out}, exp_pins(1'b1, pwm_raw, 2'b01, 2'b00));
        chk("R3 ac high bd low", {pin_oe, pin_out}, 8'hF5);
        tick(2);
        chk("R4 flag not yet", {7'd0, trip_flag}, 8'd0);
        tick(1);
        chk("R4 flag at third edge", {7'd0, trip_flag}, 8'd1);
        sw_flag(1'b0);
        chk("R8 write ignored", {7'd0, trip_flag}, 8'd1);
        cmp1_trip = 1'b0;
        tick(5);
        chk("R7 flag held", {7'd0, trip_flag}, 8'd1);
        chk("R5 pins held", {pin_oe, pin_out}, exp_pins(1'b1, pwm_raw, 2'b01, 2'b00));
        sw_flag(1'b0);
        chk("R7 cleared by write", {7'd0, trip_flag}, 8'd0);
        chk("R10 still safe after clear", {pin_oe, pin_out}, exp_pins(1'b1, pwm_raw, 2'b01, 2'b00));
        tick(2);
        period_start = 1'b1;
        #1;
        chk("R10 safe during strobe", {pin_oe, pin_out}, exp_pins(1'b1, pwm_raw, 2'b01, 2'b00));
        tick(1);
        period_start = 1'b0;
        #1;
        chk("R10 resumed", {pin_oe, pin_out}, exp_pins(1'b0, pwm_raw, 2'b01, 2'b00));
    endtask

    task automatic t_auto();
        write_cfg(3'b100, 2'b10, 2'b11, 1'b1);
        pwm_raw = 4'b0111;
        fault_n = 1'b0;
        #1;
        chk("R3 released pins", {pin_oe, pin_out}, 8'h00);
        tick(3);
        chk("R4 fault flag", {7'd0, trip_flag}, 8'd1);
        fault_n = 1'b1;
        tick(2);
        chk("R6 not yet cleared", {7'd0, trip_flag}, 8'd1);
        chk("R5 safe while flag", {pin_oe, pin_out}, 8'h00);
        tick(1);
        chk("R6 auto cleared", {7'd0, trip_flag}, 8'd0);
        tick(2);
        pulse_period();
        chk("R10 auto resume", {pin_oe, pin_out}, exp_pins(1'b0, pwm_raw, 2'b10, 2'b11));
    endtask

    task automatic t_sw_set();
        write_cfg(3'b010, 2'b00, 2'b01, 1'b0);
        pwm_raw = 4'b0101;
        sw_flag(1'b1);
        chk("R9 sw set flag", {7'd0, trip_flag}, 8'd1);
        chk("R9 sw set pins", {pin_oe, pin_out}, 8'hFA);
        tick(2);
        pulse_period();
        chk("R10 strobe with flag set", {pin_oe, pin_out}, 8'hFA);
        sw_flag(1'b0);
        tick(2);
        pulse_period();
        chk("R10 resume after sw clear", {pin_oe, pin_out}, exp_pins(1'b0, pwm_raw, 2'b00, 2'b01));
        cmp2_trip = 1'b1;
        #1;
        chk("R1 cmp2 selected", {pin_oe, pin_out}, 8'hFA);
        tick(3);
        chk("R1 cmp2 flag", {7'd0, trip_flag}, 8'd1);
        cmp2_trip = 1'b0;
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_disabled();
        t_manual();
        t_auto();
        t_sw_set();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule